// File: doc/BRIEF.md
# Smart Card Serial Control Register

This block holds the eight control bits of a serial port working in smart card mode. Software writes it through a simple single-cycle write port and reads it back on a combinational read bus. The bits switch the transmitter and receiver on and off, gate three interrupt requests, and select how the serial clock pin is driven. Two fields are interlocked against the current enable state, so a running link cannot be reconfigured by a stray write. Each write is judged against the contents the register held before that write.

A mode input chooses between two decodes of the two-bit clock-select field. In plain smart card mode (`mode_gsm` = 0) the pin is either released or carries the bit clock. In the extended mode (`mode_gsm` = 1) the pin is always driven: low, high or clocked. In that mode the field can be changed while the link runs, and the pin follows the new value on the next cycle. The bit clock arrives from the baud logic outside this block. The shifter, error detection and the interrupt controller are also outside.

Top module: `scc_ctrl_top`

## Requirements
- R1: After reset, `bus_rdata` reads 0x00, the clock pin is released in mode 0, and all interrupt requests are 0. The bit layout is as follows: bit 7 transmit-interrupt enable, bit 6 receive-interrupt enable, bit 5 transmit enable (`tx_enable`), bit 4 receive enable (`rx_enable`), bit 3 reserved, bit 2 transmit-end interrupt enable, bits 1:0 clock select.
- R2: With `mode_gsm` = 0, a write leaves the clock-select field unchanged if transmit enable or receive enable was 1 before the write.
- R3: If both enables were 0 before a write, the write loads both enable bits from the written data. If either was 1, each enable bit becomes its old value ANDed with the written bit, so a written 1 can never set an enable bit.
- R4: With `mode_gsm` = 0, clock select 00 gives `sck_oe` = 0 and `sck_level` = 0, and clock select 01 gives `sck_oe` = 1 and `sck_level` = `bit_clk`. A stored 10 or 11, which is left over from mode 1, releases the pin.
- R5: With `mode_gsm` = 1, `sck_oe` is always 1. Clock select 00 drives the pin low, 10 drives it high, and 01 or 11 drives `bit_clk`.
- R6: With `mode_gsm` = 1, the clock-select field takes every write, whatever the enables are. The pin decode follows the new value from the cycle after the write.
- R7: Bit 3 always reads 0, whatever value is written to it.
- R8: On each clock edge, `irq_tx_empty` registers `ev_tx_ready` AND bit 7. `irq_rx_full` registers `ev_rx_full` AND bit 6, and `irq_rx_err` registers `ev_rx_err` AND bit 6. Each request therefore lags its event by one cycle.
- R9: Bit 2 is stored and read back, but `irq_tx_end` is never asserted.
- R10: With `mode_gsm` = 0 and both enables 0, a write whose clock-select value is 10 or 11 leaves the field unchanged. The other fields of that write still take effect.
- R11: Both interlocks use the enable state held before the write. A single write that sets an enable bit and changes the clock-select field in mode 0 succeeds in both parts only if both enables were 0 beforehand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_gsm | input | 1 | Clock-select decode mode (0 plain, 1 extended) |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data, bits 7:0 used |
| bus_rdata | output | DATA_W | Register contents, zero-extended |
| bit_clk | input | 1 | Bit clock from the baud logic |
| ev_tx_ready | input | 1 | Transmit data empty event |
| ev_rx_full | input | 1 | Receive data full event |
| ev_rx_err | input | 1 | Receive error event |
| tx_enable | output | 1 | Transmitter enable |
| rx_enable | output | 1 | Receiver enable |
| sck_oe | output | 1 | Clock pin output enable |
| sck_level | output | 1 | Clock pin level |
| irq_tx_empty | output | 1 | Gated transmit-empty request |
| irq_rx_full | output | 1 | Gated receive-full request |
| irq_rx_err | output | 1 | Gated receive-error request |
| irq_tx_end | output | 1 | Transmit-end request, held 0 |

## Verification
A write presented before a rising edge shows in `bus_rdata` and the enable outputs just after that edge. The bench therefore drives each write on a falling edge and compares on the following falling edge. The pin outputs are combinational from the stored field, `mode_gsm` and `bit_clk`. They are checked one time step after `bit_clk` is toggled, with no edge in between. Interrupt requests lag their event by exactly one edge: events are set on a falling edge and the requests are compared on the next one. The expected register value is computed by a bench model from the old value, the written byte and the mode, and is carried forward write by write.

// File: rtl/scc_pkg.sv
package scc_pkg;

   // Bit positions are fixed because software decodes them.
   localparam int REG_W    = 8;
   localparam int B_TIE    = 7;
   localparam int B_RIE    = 6;
   localparam int B_TE     = 5;
   localparam int B_RE     = 4;
   localparam int B_RSV    = 3;
   localparam int B_TEIE   = 2;
   localparam int CKS_W    = 2;
   localparam int IRQ_N    = 3;

   // Clock-select codes.
   typedef enum logic [CKS_W-1:0] {
      CKS_LOW_OR_OFF = 2'b00,
      CKS_CLOCK      = 2'b01,
      CKS_HIGH       = 2'b10,
      CKS_CLOCK_ALT  = 2'b11
   } cks_e;

   // Packed layout matches the bit positions above (msb first).
   typedef struct packed {
      logic       tie;
      logic       rie;
      logic       te;
      logic       re;
      logic       rsv;
      logic       teie;
      logic [CKS_W-1:0] cks;
   } ctl_t;

   // Request vector order.
   localparam int IRQ_TXE = 0;
   localparam int IRQ_RXF = 1;
   localparam int IRQ_RXE = 2;

endpackage

// File: rtl/scc_ctl_reg.sv
module scc_ctl_reg
   import scc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              mode_gsm,
   output ctl_t              q
);

   localparam int USED_W = REG_W;

   generate
      if (DATA_W < USED_W) begin : g_bad_width
         $error("scc_ctl_reg: DATA_W must be at least 8");
      end
   endgenerate

   ctl_t w;
   ctl_t d;
   logic running;
   logic cks_ok;

   assign w       = ctl_t'(wdata[USED_W-1:0]);
   assign running = q.te | q.re;

   // Clock-select acceptance is judged on the pre-write state.
   always_comb begin
      if (mode_gsm) cks_ok = 1'b1;
      else          cks_ok = !running && !w.cks[CKS_W-1];
   end

   always_comb begin
      d = q;
      if (wr) begin
         d.tie  = w.tie;
         d.rie  = w.rie;
         d.teie = w.teie;
         d.rsv  = 1'b0;
         if (running) begin
            d.te = q.te & w.te;
            d.re = q.re & w.re;
         end else begin
            d.te = w.te;
            d.re = w.re;
         end
         if (cks_ok) d.cks = w.cks;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/scc_clk_pin.sv
module scc_clk_pin
   import scc_pkg::*;
#(
   parameter bit REL_LEVEL = 1'b0
) (
   input  logic             mode_gsm,
   input  logic [CKS_W-1:0] cks,
   input  logic             bit_clk,
   output logic             oe,
   output logic             lvl
);

   cks_e sel;
   assign sel = cks_e'(cks);

   always_comb begin
      oe  = 1'b0;
      lvl = REL_LEVEL;
      if (mode_gsm) begin
         oe = 1'b1;
         unique case (sel)
            CKS_LOW_OR_OFF: lvl = 1'b0;
            CKS_HIGH:       lvl = 1'b1;
            CKS_CLOCK,
            CKS_CLOCK_ALT:  lvl = bit_clk;
            default:        lvl = 1'b0;
         endcase
      end else begin
         if (sel == CKS_CLOCK) begin
            oe  = 1'b1;
            lvl = bit_clk;
         end
      end
   end

endmodule

// File: rtl/scc_irq_gate.sv
module scc_irq_gate #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] en,
   output logic [N-1:0] req
);

   generate
      if (N < 1) begin : g_bad_n
         $error("scc_irq_gate: N must be positive");
      end
      for (genvar i = 0; i < N; i++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req[i] <= 1'b0;
            else        req[i] <= ev[i] & en[i];
         end
      end
   endgenerate

endmodule

// File: rtl/scc_ctrl_top.sv
module scc_ctrl_top
   import scc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_gsm,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              bit_clk,
   input  logic              ev_tx_ready,
   input  logic              ev_rx_full,
   input  logic              ev_rx_err,
   output logic              tx_enable,
   output logic              rx_enable,
   output logic              sck_oe,
   output logic              sck_level,
   output logic              irq_tx_empty,
   output logic              irq_rx_full,
   output logic              irq_rx_err,
   output logic              irq_tx_end
);

   ctl_t             ctl;
   logic [IRQ_N-1:0] ev_v;
   logic [IRQ_N-1:0] en_v;
   logic [IRQ_N-1:0] req_v;

   scc_ctl_reg #(.DATA_W(DATA_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr),
      .wdata    (bus_wdata),
      .mode_gsm (mode_gsm),
      .q        (ctl)
   );

   scc_clk_pin #(.REL_LEVEL(1'b0)) u_pin (
      .mode_gsm (mode_gsm),
      .cks      (ctl.cks),
      .bit_clk  (bit_clk),
      .oe       (sck_oe),
      .lvl      (sck_level)
   );

   assign ev_v[IRQ_TXE] = ev_tx_ready;
   assign ev_v[IRQ_RXF] = ev_rx_full;
   assign ev_v[IRQ_RXE] = ev_rx_err;
   assign en_v[IRQ_TXE] = ctl.tie;
   assign en_v[IRQ_RXF] = ctl.rie;
   assign en_v[IRQ_RXE] = ctl.rie;

   scc_irq_gate #(.N(IRQ_N)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev_v),
      .en    (en_v),
      .req   (req_v)
   );

   assign irq_tx_empty = req_v[IRQ_TXE];
   assign irq_rx_full  = req_v[IRQ_RXF];
   assign irq_rx_err   = req_v[IRQ_RXE];
   // No transmit-end request exists in smart card mode.
   assign irq_tx_end   = 1'b0;

   assign bus_rdata = DATA_W'(ctl);
   assign tx_enable = ctl.te;
   assign rx_enable = ctl.re;

endmodule

module scc_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_gsm,
   input logic [7:0] rd,
   input logic       bit_clk,
   input logic       ev_tx_ready,
   input logic       ev_rx_full,
   input logic       ev_rx_err,
   input logic       tx_enable,
   input logic       rx_enable,
   input logic       sck_oe,
   input logic       sck_level,
   input logic       irq_tx_empty,
   input logic       irq_rx_full,
   input logic       irq_rx_err
);

   // R2: clock select frozen in mode 0 while the link is enabled
   p_cks_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_gsm && (tx_enable || rx_enable)) |=> $stable(rd[1:0]));

   // R3: no enable rises while either is already on
   p_en_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_enable || rx_enable) |=> (!$rose(tx_enable) && !$rose(rx_enable)));

   // R4: mode 0, field 00 releases the pin
   p_pin_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_gsm && rd[1:0] == 2'b00) |-> !sck_oe);

   // R5: mode 1 always drives; 10 gives high
   p_pin_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_gsm && rd[1:0] == 2'b10) |-> (sck_oe && sck_level));

   // R5: mode 1, field 01 carries the bit clock
   p_pin_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_gsm && rd[1:0] == 2'b01) |-> (sck_oe && sck_level == bit_clk));

   // R10: the upper clock-select bit cannot rise by a mode-0 write
   p_no_prohib_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_gsm |=> !$rose(rd[1]));

   // R8: receive requests follow gated events one cycle later
   p_rx_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_rx_full == ($past(ev_rx_full) && $past(rd[6]))
             && irq_rx_err == ($past(ev_rx_err) && $past(rd[6]))));

   // R8: transmit request follows its gated event one cycle later
   p_tx_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_tx_empty == ($past(ev_tx_ready) && $past(rd[7]))));

   // R7: reserved bit reads zero
   p_rsv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd[3]) == 1'b0 |-> rd[3] == 1'b0);

endmodule

bind scc_ctrl_top scc_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_gsm     (mode_gsm),
   .rd           (bus_rdata[7:0]),
   .bit_clk      (bit_clk),
   .ev_tx_ready  (ev_tx_ready),
   .ev_rx_full   (ev_rx_full),
   .ev_rx_err    (ev_rx_err),
   .tx_enable    (tx_enable),
   .rx_enable    (rx_enable),
   .sck_oe       (sck_oe),
   .sck_level    (sck_level),
   .irq_tx_empty (irq_tx_empty),
   .irq_rx_full  (irq_rx_full),
   .irq_rx_err   (irq_rx_err)
);

// File: tb/tb_scc_ctrl_top.sv
module tb_scc_ctrl_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_gsm = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       bit_clk = 1'b0;
   logic       ev_tx_ready = 1'b0, ev_rx_full = 1'b0, ev_rx_err = 1'b0;
   logic       tx_enable, rx_enable, sck_oe, sck_level;
   logic       irq_tx_empty, irq_rx_full, irq_rx_err, irq_tx_end;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   logic [7:0] model = '0;

   always #10 clk = ~clk;

   scc_ctrl_top #(.DATA_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .mode_gsm(mode_gsm),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bit_clk(bit_clk), .ev_tx_ready(ev_tx_ready), .ev_rx_full(ev_rx_full),
      .ev_rx_err(ev_rx_err), .tx_enable(tx_enable), .rx_enable(rx_enable),
      .sck_oe(sck_oe), .sck_level(sck_level), .irq_tx_empty(irq_tx_empty),
      .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err), .irq_tx_end(irq_tx_end)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // Expected register after a write, built from the requirement text.
   function automatic logic [7:0] next_val(input logic [7:0] old, input logic [7:0] wd,
                                           input logic gsm);
      logic [7:0] r;
      logic on;
      on = old[5] | old[4];
      r  = {wd[7], wd[6], 2'b00, 1'b0, wd[2], old[1:0]};
      if (on) begin
         r[5] = old[5] & wd[5];
         r[4] = old[4] & wd[4];
      end else begin
         r[5] = wd[5];
         r[4] = wd[4];
      end
      if (gsm || (!on && !wd[1])) r[1:0] = wd[1:0];
      return r;
   endfunction

   task automatic do_wr(input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1;
      bus_wdata = d;
      model = next_val(model, d, mode_gsm);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic pin_check();
      logic [1:0] exp;
      for (int b = 0; b < 2; b++) begin
         bit_clk = b[0];
         #1;
         if (mode_gsm) begin
            case (model[1:0])
               2'b00: exp = 2'b10;
               2'b10: exp = 2'b11;
               default: exp = {1'b1, b[0]};
            endcase
            chk("R5 R6 pin", {6'd0, sck_oe, sck_level}, {6'd0, exp});
         end else begin
            exp = (model[1:0] == 2'b01) ? {1'b1, b[0]} : 2'b00;
            chk("R4 pin", {6'd0, sck_oe, sck_level}, {6'd0, exp});
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] wset [16];
      wset = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h30, 8'h31, 8'h32, 8'h13,
               8'h20, 8'h10, 8'hFF, 8'hCD, 8'h08, 8'h04, 8'h22, 8'h11};
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset rdata", bus_rdata, 8'h00);
      chk("R1 reset pin", {6'd0, sck_oe, sck_level}, 8'h00);
      chk("R1 reset irq", {4'd0, irq_tx_empty, irq_rx_full, irq_rx_err, irq_tx_end}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // Sweep: every first write from idle, then a second write against that state.
      for (int m = 0; m < 2; m++) begin
         mode_gsm = m[0];
         for (int v = 0; v < 256; v++) begin
            for (int k = 0; k < 16; k++) begin
               do_wr(8'h00);
               do_wr(8'h00);
               chk("R3 idle", bus_rdata, model);
               do_wr(v[7:0]);
               chk("R1 R2 R3 R7 R9 R10 R11 first", bus_rdata, model);
               chk("R3 enables", {6'd0, tx_enable, rx_enable}, {6'd0, model[5], model[4]});
               do_wr(wset[k]);
               chk("R2 R3 R6 R7 R10 R11 second", bus_rdata, model);
               pin_check();
            end
         end
      end

      // R11 explicit: set TE and change clock select in one write, from idle.
      mode_gsm = 1'b0;
      do_wr(8'h00); do_wr(8'h00);
      do_wr(8'h21);
      chk("R11 joint write", bus_rdata, 8'h21);
      do_wr(8'h20);
      chk("R2 locked cks", bus_rdata, 8'h21);
      do_wr(8'h31);
      chk("R3 no set while on", bus_rdata, 8'h21);

      // R6: mode 1 dynamic change while running.
      mode_gsm = 1'b1;
      do_wr(8'h22);
      pin_check();
      chk("R6 running cks", bus_rdata, 8'h22);
      do_wr(8'h20);
      pin_check();

      // R8 / R9: interrupt gating, one cycle latency.
      for (int en = 0; en < 8; en++) begin
         do_wr({en[1], en[0], 3'b000, en[2], 2'b00});
         for (int e = 0; e < 8; e++) begin
            @(negedge clk);
            ev_tx_ready = e[0]; ev_rx_full = e[1]; ev_rx_err = e[2];
            @(negedge clk);
            chk("R8 irq", {5'd0, irq_tx_empty, irq_rx_full, irq_rx_err},
                {5'd0, e[0] & en[1], e[1] & en[0], e[2] & en[0]});
            chk("R9 tx end", {7'd0, irq_tx_end}, 8'h00);
         end
         chk("R9 teie readback", {7'd0, bus_rdata[2]}, {7'd0, en[2]});
      end
      ev_tx_ready = 0; ev_rx_full = 0; ev_rx_err = 0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule